// File: doc/BRIEF.md
# Two-Wire Register and Command Slave

This block is the serial front end of a four-channel wiper device. It watches a two-wire bus (clock and open-drain data), both oversampled by a fast system clock. It finds start and stop conditions and checks the 7-bit address. After the address it decodes an instruction byte, which chooses between two uses. One is a register access that sets a pointer into the wiper bank or the nonvolatile bank. The other is a quick command that is handed to the adjustment and storage logic.

Data bytes that follow a register access become one-cycle write strobes toward the register map, and the pointer advances after each one. Reads return bytes from the register map, starting at the current pointer. A random read is done in two steps: a write that carries only the instruction byte sets the pointer, and a read follows it. While the nonvolatile store is busy, the block does not acknowledge its address, so software polls with the address until an acknowledge appears.

Top module: `twowire_cmd_slave`

## Requirements
- R1: After reset the block does not drive the data line (`sda_oe` low), and `wr_en` and `cmd_valid` are low.
- R2: An address byte whose upper seven bits equal binary 01011 followed by `addr_pins[1:0]` is acknowledged, and its bit 0 selects read (1) or write (0). Any other address is not acknowledged, and the bytes after it until the next start produce no write and no command.
- R3: While `busy_i` is high, the block does not acknowledge its own address.
- R4: In a write, an instruction byte with bit 7 clear sets the bank from bit 5 (1 nonvolatile, 0 wiper) and the pointer from bits 4:0. Each data byte after it is acknowledged and gives a one-cycle `wr_en` with the bank, pointer and byte.
- R5: After each data byte is written, and after each read byte the master acknowledges, the pointer advances. In the wiper bank it wraps from 7 to 0, and in the nonvolatile bank from 31 to 0.
- R6: Nonvolatile addresses 24 to 31 are read-only. A data byte aimed at one of them is acknowledged but gives no `wr_en`, and the pointer still advances.
- R7: An instruction byte with bit 7 set is a quick command. It gives a one-cycle `cmd_valid` with the code from bits 6:3 and the channel from bits 2:0. A data byte after it is optional, and if sent it is acknowledged and gives no write.
- R8: In a read, bytes come from `rd_data` at the current pointer, most significant bit first. SDA is driven only while SCL is low. A not-acknowledge from the master ends the read and releases SDA, and the pointer then stays on the last byte sent.
- R9: A write that stops after the instruction byte, followed by a repeated start and a read, returns data starting at the address that was just set.
- R10: A start condition in the middle of a byte drops that byte and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| sda_oe | output | 1 | Pulls the data line low when high |
| addr_pins | input | 2 | Strap value for the two low address bits |
| busy_i | input | 1 | Nonvolatile write cycle in progress |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_nv | output | 1 | Bank of the write: 1 nonvolatile, 0 wiper |
| wr_addr | output | 5 | Register address of the write |
| wr_data | output | 8 | Byte to write |
| rd_nv | output | 1 | Bank of the read pointer |
| rd_addr | output | 5 | Read pointer address |
| rd_data | input | 8 | Register map content at the read pointer |
| cmd_valid | output | 1 | One-cycle quick command strobe |
| cmd_code | output | 4 | Quick command code |
| cmd_chan | output | 3 | Channel field of the quick command |

## Verification
The main patterns are a single register write and a burst write across the wiper wrap point. These show that the pointer comes from the instruction byte and that it wraps at eight. A burst into the nonvolatile bank that starts at a read-only address separates the suppressed strobe from the pointer advance. A quick command sent with a data byte and without one shows that the command path never reaches the write strobe. A random read followed by a read with no address checks both the wrap on reads and that the pointer stays put after a not-acknowledge. A wrong address, a busy poll and an abandoned half byte separate a refused transaction from a restarted one.

// File: rtl/twowire_cmd_slave.sv
module twowire_cmd_slave #(
  parameter logic [4:0] ADDR_HI = 5'b01011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] addr_pins,
  input  logic       busy_i,
  output logic       wr_en,
  output logic       wr_nv,
  output logic [4:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       rd_nv,
  output logic [4:0] rd_addr,
  input  logic [7:0] rd_data,
  output logic       cmd_valid,
  output logic [3:0] cmd_code,
  output logic [2:0] cmd_chan
);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RACK, S_TX, S_TACK} st_t;

  st_t        st;
  logic [2:0] scl_sr, sda_sr;
  logic [7:0] sh;
  logic [3:0] cnt;
  logic [1:0] phase;
  logic       rw, cmd_mode, ptr_nv;
  logic [4:0] ptr, ptr_nxt;

  wire scl_rise = scl_sr[1] & ~scl_sr[2];
  wire scl_fall = ~scl_sr[1] & scl_sr[2];
  wire scl_hi   = scl_sr[1] & scl_sr[2];
  wire start_c  = scl_hi & sda_sr[2] & ~sda_sr[1];
  wire stop_c   = scl_hi & ~sda_sr[2] & sda_sr[1];
  wire sda_b    = sda_sr[1];
  wire ro_hit   = ptr_nv & (ptr[4:3] == 2'b11);

  assign ptr_nxt = ptr_nv ? ptr + 5'd1 : {2'b00, ptr[2:0] + 3'd1};
  assign rd_nv   = ptr_nv;
  assign rd_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= 3'b111;
      sda_sr <= 3'b111;
    end else begin
      scl_sr <= {scl_sr[1:0], scl_i};
      sda_sr <= {sda_sr[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sh        <= '0;
      cnt       <= '0;
      phase     <= '0;
      rw        <= 1'b0;
      cmd_mode  <= 1'b0;
      ptr_nv    <= 1'b0;
      ptr       <= '0;
      sda_oe    <= 1'b0;
      wr_en     <= 1'b0;
      wr_nv     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
      cmd_chan  <= '0;
    end else begin
      wr_en     <= 1'b0;
      cmd_valid <= 1'b0;
      if (start_c) begin
        st       <= S_RX;
        cnt      <= '0;
        phase    <= 2'd0;
        sda_oe   <= 1'b0;
        cmd_mode <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_b};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (phase == 2'd0) begin
                if (sh[7:1] == {ADDR_HI, addr_pins} && !busy_i) begin
                  rw     <= sh[0];
                  sda_oe <= 1'b1;
                  st     <= S_RACK;
                  phase  <= 2'd1;
                end else begin
                  st <= S_IDLE;
                end
              end else if (phase == 2'd1) begin
                sda_oe <= 1'b1;
                st     <= S_RACK;
                phase  <= 2'd2;
                if (sh[7]) begin
                  cmd_mode  <= 1'b1;
                  cmd_valid <= 1'b1;
                  cmd_code  <= sh[6:3];
                  cmd_chan  <= sh[2:0];
                end else begin
                  ptr_nv <= sh[5];
                  ptr    <= sh[4:0];
                end
              end else begin
                sda_oe <= 1'b1;
                st     <= S_RACK;
                if (!cmd_mode) begin
                  wr_en   <= ~ro_hit;
                  wr_nv   <= ptr_nv;
                  wr_addr <= ptr;
                  wr_data <= sh;
                  ptr     <= ptr_nxt;
                end
              end
            end
          end
          S_RACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                sh     <= rd_data;
                sda_oe <= ~rd_data[7];
                st     <= S_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= S_TACK;
              end else begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
              end
            end
          end
          S_TACK: begin
            if (scl_rise) begin
              if (!sda_b) begin
                ptr <= ptr_nxt;
                st  <= S_RACK;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

module twowire_cmd_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       wr_en,
  input logic       wr_nv,
  input logic [4:0] wr_addr,
  input logic       cmd_valid
);

  assert_ro_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !(wr_nv && wr_addr[4:3] == 2'b11));

  assert_wr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  assert_cmd_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  assert_cmd_not_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, cmd_valid}));

  assert_drive_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

endmodule

bind twowire_cmd_slave twowire_cmd_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .wr_en(wr_en), .wr_nv(wr_nv), .wr_addr(wr_addr), .cmd_valid(cmd_valid)
);

// File: tb/twowire_cmd_slave_tb.sv
`timescale 1ns/1ps
module twowire_cmd_slave_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic busy = 1'b0;
  logic [1:0] pins = 2'b10;
  logic sda_oe, wr_en, wr_nv, rd_nv, cmd_valid;
  logic [4:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [3:0] cmd_code;
  logic [2:0] cmd_chan;
  wire sda_bus = sda_m & ~sda_oe;

  int checks = 0, failures = 0;
  int wr_cnt = 0, cmd_cnt = 0;
  logic [4:0] last_wa;
  logic       last_wnv;
  logic [7:0] last_wd;
  logic [3:0] last_code;
  logic [2:0] last_chan;
  logic [7:0] wip [0:7];
  logic [7:0] nvm [0:31];
  logic [4:0] seen_wa [0:7];

  always #4 clk = ~clk;

  twowire_cmd_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_pins(pins), .busy_i(busy), .wr_en(wr_en), .wr_nv(wr_nv),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_nv(rd_nv), .rd_addr(rd_addr),
    .rd_data(rd_data), .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_chan(cmd_chan)
  );

  assign rd_data = rd_nv ? nvm[rd_addr] : wip[rd_addr[2:0]];

  initial begin
    for (int i = 0; i < 8; i++) wip[i] = 8'h00;
    for (int i = 0; i < 32; i++) nvm[i] = 8'h00;
    nvm[24] = 8'h1C;
    nvm[25] = 8'h0F;
  end

  always @(posedge clk) begin
    if (wr_en) begin
      if (wr_cnt < 8) seen_wa[wr_cnt] = wr_addr;
      wr_cnt   = wr_cnt + 1;
      last_wa  = wr_addr;
      last_wnv = wr_nv;
      last_wd  = wr_data;
      if (wr_nv) nvm[wr_addr] = wr_data;
      else wip[wr_addr[2:0]] = wr_data;
    end
    if (cmd_valid) begin
      cmd_cnt   = cmd_cnt + 1;
      last_code = cmd_code;
      last_chan = cmd_chan;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(5);
    scl_m = 1'b1; tick(10);
    sda_m = 1'b0; tick(10);
    scl_m = 1'b0; tick(5);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(5);
    scl_m = 1'b1; tick(10);
    sda_m = 1'b1; tick(10);
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(5);
      scl_m = 1'b1; tick(10);
      scl_m = 1'b0; tick(5);
    end
    sda_m = 1'b1; tick(5);
    scl_m = 1'b1; tick(5);
    ack = ~sda_bus; tick(5);
    scl_m = 1'b0; tick(5);
  endtask

  task automatic recv(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(5);
      scl_m = 1'b1; tick(5);
      b = {b[6:0], sda_bus}; tick(5);
      scl_m = 1'b0;
    end
    tick(5);
    sda_m = ~mack; tick(5);
    scl_m = 1'b1; tick(10);
    scl_m = 1'b0; tick(5);
    sda_m = 1'b1;
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
    chk(wr_en == 1'b0, "R1 wr_en", wr_en, 0);
    chk(cmd_valid == 1'b0, "R1 cmd_valid", cmd_valid, 0);
  endtask

  task automatic t_single_write();
    logic a0, a1, a2;
    int base = wr_cnt;
    i2c_start();
    send(8'h5C, a0); send(8'h03, a1); send(8'hA5, a2);
    i2c_stop();
    chk(a0, "R2 address ack", a0, 1);
    chk(a1 && a2, "R4 instr/data ack", {a1, a2}, 3);
    chk(wr_cnt == base + 1, "R4 write count", wr_cnt - base, 1);
    chk(last_wa == 5'd3 && !last_wnv && last_wd == 8'hA5, "R4 write fields",
        {last_wnv, last_wa, last_wd}, {1'b0, 5'd3, 8'hA5});
  endtask

  task automatic t_wrong_addr();
    logic a0, a1, a2;
    int base = wr_cnt;
    i2c_start();
    send(8'h58, a0); send(8'h03, a1); send(8'h77, a2);
    i2c_stop();
    chk(!a0, "R2 wrong address nack", a0, 0);
    chk(!a1 && !a2, "R2 later bytes nack", {a1, a2}, 0);
    chk(wr_cnt == base, "R2 no write after refused address", wr_cnt - base, 0);
  endtask

  task automatic t_wiper_wrap();
    logic a;
    int base = wr_cnt;
    i2c_start();
    send(8'h5C, a); send(8'h06, a);
    send(8'h11, a); send(8'h22, a); send(8'h33, a);
    i2c_stop();
    chk(wr_cnt == base + 3, "R5 burst count", wr_cnt - base, 3);
    chk(seen_wa[base] == 5'd6 && seen_wa[base+1] == 5'd7 && seen_wa[base+2] == 5'd0,
        "R5 wiper wrap 6,7,0", {seen_wa[base], seen_wa[base+1], seen_wa[base+2]},
        {5'd6, 5'd7, 5'd0});
  endtask

  task automatic t_nv_wrap_ro();
    logic a1, a2;
    logic a;
    int base = wr_cnt;
    i2c_start();
    send(8'h5C, a); send(8'h3F, a);
    send(8'h44, a1); send(8'h55, a2);
    i2c_stop();
    chk(a1, "R6 read-only byte acked", a1, 1);
    chk(wr_cnt == base + 1, "R6 only one write", wr_cnt - base, 1);
    chk(last_wnv && last_wa == 5'd0 && last_wd == 8'h55, "R5 nv wrap 31 to 0",
        {last_wnv, last_wa, last_wd}, {1'b1, 5'd0, 8'h55});
  endtask

  task automatic t_readonly_read();
    logic a;
    logic [7:0] b0, b1;
    int base = wr_cnt;
    i2c_start();
    send(8'h5C, a); send(8'h38, a); send(8'h99, a);
    i2c_stop();
    chk(wr_cnt == base, "R6 tolerance write dropped", wr_cnt - base, 0);
    i2c_start();
    send(8'h5C, a); send(8'h38, a);
    i2c_start();
    send(8'h5D, a);
    recv(1'b1, b0); recv(1'b0, b1);
    i2c_stop();
    chk(b0 == 8'h1C && b1 == 8'h0F, "R6 tolerance bytes unchanged", {b0, b1}, 16'h1C0F);
  endtask

  task automatic t_command();
    logic a1, a2;
    logic a;
    int base = wr_cnt;
    int cbase = cmd_cnt;
    i2c_start();
    send(8'h5C, a); send(8'hDA, a1); send(8'h42, a2);
    i2c_stop();
    chk(cmd_cnt == cbase + 1, "R7 one command", cmd_cnt - cbase, 1);
    chk(last_code == 4'hB && last_chan == 3'd2, "R7 code/channel",
        {last_code, last_chan}, {4'hB, 3'd2});
    chk(a1 && a2 && wr_cnt == base, "R7 data acked, no write", wr_cnt - base, 0);
    i2c_start();
    send(8'h5C, a); send(8'hA1, a);
    i2c_stop();
    chk(cmd_cnt == cbase + 2 && last_code == 4'h4 && last_chan == 3'd1,
        "R7 command without data", {last_code, last_chan}, {4'h4, 3'd1});
  endtask

  task automatic t_random_read();
    logic a;
    logic [7:0] b0, b1, b2;
    i2c_start();
    send(8'h5C, a); send(8'h06, a);
    i2c_start();
    send(8'h5D, a);
    chk(a, "R2 read address ack", a, 1);
    recv(1'b1, b0); recv(1'b1, b1); recv(1'b0, b2);
    tick(10);
    chk(sda_oe == 1'b0, "R8 released after nack", sda_oe, 0);
    i2c_stop();
    chk(b0 == 8'h11, "R9 first byte at set pointer", b0, 8'h11);
    chk(b1 == 8'h22 && b2 == 8'h33, "R5 read wraps 7 to 0", {b1, b2}, 16'h2233);
  endtask

  task automatic t_current_read();
    logic a;
    logic [7:0] b0, b1;
    i2c_start();
    send(8'h5D, a);
    recv(1'b1, b0); recv(1'b0, b1);
    i2c_stop();
    chk(b0 == 8'h33, "R8 current read at held pointer", b0, 8'h33);
    chk(b1 == 8'h00, "R8 next byte", b1, 8'h00);
  endtask

  task automatic t_busy();
    logic a;
    busy = 1'b1;
    i2c_start(); send(8'h5C, a); i2c_stop();
    chk(!a, "R3 busy nack", a, 0);
    busy = 1'b0;
    i2c_start(); send(8'h5C, a); i2c_stop();
    chk(a, "R3 ack after busy", a, 1);
  endtask

  task automatic t_restart();
    logic a0, a;
    int base = wr_cnt;
    int cbase = cmd_cnt;
    i2c_start();
    send(8'h5C, a);
    for (int i = 0; i < 4; i++) begin
      sda_m = 1'b1; tick(5);
      scl_m = 1'b1; tick(10);
      scl_m = 1'b0; tick(5);
    end
    i2c_start();
    send(8'h5C, a0); send(8'h01, a); send(8'h7E, a);
    i2c_stop();
    chk(a0, "R10 address after restart", a0, 1);
    chk(cmd_cnt == cbase, "R10 partial byte dropped", cmd_cnt - cbase, 0);
    chk(wr_cnt == base + 1 && last_wa == 5'd1 && last_wd == 8'h7E, "R10 write after restart",
        {last_wa, last_wd}, {5'd1, 8'h7E});
  endtask

  initial begin
    tick(5);
    t_reset();
    rst_n = 1'b1;
    tick(10);
    t_single_write();
    t_wrong_addr();
    t_wiper_wrap();
    t_nv_wrap_ro();
    t_readonly_read();
    t_command();
    t_random_read();
    t_current_read();
    t_busy();
    t_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule